// File: doc/BRIEF.md
# Two-Level Lookahead Adder/Subtractor

This block is a purely combinational adder/subtractor for 16-bit two's-complement or unsigned operands. It is built for datapaths that need a short carry path. Each bit position forms a generate term and a propagate term. The bits are collected into four 4-bit groups. Each group reduces its bits to one group-generate and one group-propagate. A second lookahead unit combines those group terms to produce the carry into every group. As a result, no carry travels serially from one bit to the next.

The mode input chooses between A + B + cin and A − B − cin. To subtract, the block inverts the second operand and inverts the incoming carry. With cin low, this gives A + ~B + 1; with cin high, cin acts as a borrow-in. The outputs are the modulo-2^16 result, the raw carry out of the most significant bit, and a signed overflow flag that is derived from the operand and result signs.

Top module: `cla_addsub`

## Requirements
- R1: With `sub_en`=0, `sum_o` equals (`op_a` + `op_b` + `carry_in`) modulo 2^16.
- R2: With `sub_en`=0, `carry_o` equals bit 16 of the unsigned 17-bit sum `op_a` + `op_b` + `carry_in`.
- R3: With `sub_en`=1, `sum_o` equals (`op_a` − `op_b` − `carry_in`) modulo 2^16, so that `carry_in` acts as a borrow-in.
- R4: With `sub_en`=1, `carry_o` is 1 exactly when `op_a` ≥ `op_b` + `carry_in` taken as unsigned values, meaning no borrow is produced.
- R5: With `sub_en`=0, `ovf_o` is 1 exactly when the signed sum (bit 15 is the sign) falls outside −32768..32767. This happens only when both operands have the same sign and the result sign differs from it.
- R6: With `sub_en`=0 and operands of opposite sign, `ovf_o` is 0.
- R7: With `sub_en`=1, `ovf_o` is 1 exactly when the signed difference falls outside −32768..32767. This happens only for a negative minus a non-negative value giving sign 0, or a non-negative minus a negative value giving sign 1.
- R8: With `sub_en`=1 and operands of equal sign, `ovf_o` is 0.
- R9: A carry that starts in bit 0 reaches every group boundary and the carry out. For example, 0xFFFF + 0x0000 + 1 gives sum 0x0000 with carry 1, and 0x0FFF + 0x0001 gives 0x1000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand (subtrahend in subtract mode) |
| sub_en | input | 1 | 0: add, 1: subtract |
| carry_in | input | 1 | Carry-in when adding, borrow-in when subtracting |
| sum_o | output | 16 | Result modulo 2^16 |
| carry_o | output | 1 | Carry out of bit 15 (in subtract mode, 1 = no borrow) |
| ovf_o | output | 1 | Signed overflow |

## Verification
The bench targets carries that must cross every group boundary: all-ones plus one, 0x0FFF + 1, and 0x00FF + 0x0001. A design that wires a group carry-in to the wrong group, or drops a term of the second-level equation, produces a sum that is wrong in a single nibble. The signed limits 0x7FFF + 1 and 0x8000 − 1, together with all-ones operands, expose an overflow flag built from the unsigned carry instead of the signs, or a subtract path that leaves out the +1. Random operands are compared against a ripple-carry reference, and these comparisons catch a sum built from the OR-based propagate instead of the XOR.

// File: rtl/cla_pkg.sv
package cla_pkg;
  localparam int CLA_WIDTH = 16;
  localparam int CLA_GRP_W = 4;

  typedef struct packed {
    logic gen;
    logic prop;
  } cla_gp_t;
endpackage

// File: rtl/cla_bit_terms.sv
module cla_bit_terms #(
  parameter int W = 16
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  output logic [W-1:0] gen_o,
  output logic [W-1:0] prop_o,
  output logic [W-1:0] half_o
);
  genvar gi;
  generate
    for (gi = 0; gi < W; gi++) begin : g_bit
      assign gen_o[gi]  = x_i[gi] & y_i[gi];
      assign prop_o[gi] = x_i[gi] | y_i[gi];
      assign half_o[gi] = x_i[gi] ^ y_i[gi];
    end
  endgenerate
endmodule

// File: rtl/cla_lookahead.sv
// Generic N-input lookahead unit. It produces the internal carries
// c1..c(N-1) in sum-of-products form, plus the block-level generate
// and propagate terms.
module cla_lookahead #(
  parameter int N = 4
) (
  input  logic [N-1:0] gen_i,
  input  logic [N-1:0] prop_i,
  input  logic         cin_i,
  output logic [N-2:0] carry_o,
  output logic         blk_gen_o,
  output logic         blk_prop_o
);
  logic acc;
  logic term;
  logic gacc;
  logic gterm;

  always_comb begin
    acc  = 1'b0;
    term = 1'b0;
    for (int i = 0; i < N - 1; i++) begin
      acc = cin_i;
      for (int k = 0; k <= i; k++) acc = acc & prop_i[k];
      for (int j = 0; j <= i; j++) begin
        term = gen_i[j];
        for (int k = j + 1; k <= i; k++) term = term & prop_i[k];
        acc = acc | term;
      end
      carry_o[i] = acc;
    end
  end

  always_comb begin
    gacc  = 1'b0;
    gterm = 1'b0;
    for (int j = 0; j < N; j++) begin
      gterm = gen_i[j];
      for (int k = j + 1; k < N; k++) gterm = gterm & prop_i[k];
      gacc = gacc | gterm;
    end
    blk_gen_o  = gacc;
    blk_prop_o = &prop_i;
  end
endmodule

// File: rtl/cla_addsub.sv
module cla_addsub
  import cla_pkg::*;
#(
  parameter int WIDTH = CLA_WIDTH,
  parameter int GRP_W = CLA_GRP_W
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             sub_en,
  input  logic             carry_in,
  output logic [WIDTH-1:0] sum_o,
  output logic             carry_o,
  output logic             ovf_o
);
  localparam int NGRP = WIDTH / GRP_W;
  localparam int MSB  = WIDTH - 1;

  logic [WIDTH-1:0] b_eff;
  logic             c0;
  logic [WIDTH-1:0] bit_g, bit_p, bit_h;
  logic [WIDTH-1:0] bit_c;
  logic [NGRP-1:0]  grp_cin;
  cla_gp_t [NGRP-1:0] grp_gp;
  logic [NGRP-1:0]  grp_g, grp_p;
  logic [NGRP-2:0]  l2_carry;
  logic             all_g, all_p;

  assign b_eff = op_b ^ {WIDTH{sub_en}};
  assign c0    = carry_in ^ sub_en;

  cla_bit_terms #(.W(WIDTH)) u_terms (
    .x_i   (op_a),
    .y_i   (b_eff),
    .gen_o (bit_g),
    .prop_o(bit_p),
    .half_o(bit_h)
  );

  genvar gk;
  generate
    for (gk = 0; gk < NGRP; gk++) begin : g_grp
      logic [GRP_W-2:0] inner_c;
      logic             gg, gp;
      cla_lookahead #(.N(GRP_W)) u_grp (
        .gen_i     (bit_g[gk*GRP_W +: GRP_W]),
        .prop_i    (bit_p[gk*GRP_W +: GRP_W]),
        .cin_i     (grp_cin[gk]),
        .carry_o   (inner_c),
        .blk_gen_o (gg),
        .blk_prop_o(gp)
      );
      assign grp_gp[gk].gen  = gg;
      assign grp_gp[gk].prop = gp;
      assign grp_g[gk] = grp_gp[gk].gen;
      assign grp_p[gk] = grp_gp[gk].prop;
      assign bit_c[gk*GRP_W]                  = grp_cin[gk];
      assign bit_c[gk*GRP_W+1 +: GRP_W-1]     = inner_c;
    end
  endgenerate

  cla_lookahead #(.N(NGRP)) u_level2 (
    .gen_i     (grp_g),
    .prop_i    (grp_p),
    .cin_i     (c0),
    .carry_o   (l2_carry),
    .blk_gen_o (all_g),
    .blk_prop_o(all_p)
  );

  assign grp_cin = {l2_carry, c0};

  assign sum_o   = bit_h ^ bit_c;
  assign carry_o = all_g | (all_p & c0);
  assign ovf_o   = (op_a[MSB] ~^ b_eff[MSB]) & (sum_o[MSB] ^ op_a[MSB]);
endmodule

// File: rtl/cla_addsub_chk.sv
module cla_addsub_chk #(
  parameter int WIDTH = 16
) (
  input logic [WIDTH-1:0] op_a,
  input logic [WIDTH-1:0] op_b,
  input logic             sub_en,
  input logic             carry_in,
  input logic [WIDTH-1:0] sum_o,
  input logic             carry_o,
  input logic             ovf_o
);
  logic [WIDTH:0]   add_wide;
  logic [WIDTH-1:0] diff_ref;
  logic             no_borrow;
  logic signed [WIDTH+1:0] s_res;
  logic             ovf_ref;

  always_comb begin
    add_wide  = {1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in};
    diff_ref  = op_a - op_b - {{(WIDTH-1){1'b0}}, carry_in};
    no_borrow = ({1'b0, op_a} >= ({1'b0, op_b} + {{WIDTH{1'b0}}, carry_in}));
    if (sub_en)
      s_res = $signed({{2{op_a[WIDTH-1]}}, op_a}) - $signed({{2{op_b[WIDTH-1]}}, op_b})
              - $signed({{(WIDTH+1){1'b0}}, carry_in});
    else
      s_res = $signed({{2{op_a[WIDTH-1]}}, op_a}) + $signed({{2{op_b[WIDTH-1]}}, op_b})
              + $signed({{(WIDTH+1){1'b0}}, carry_in});
    ovf_ref = (s_res[WIDTH+1:WIDTH-1] != {3{s_res[WIDTH-1]}});
  end

  always_comb begin
    if (!sub_en) begin
      a_r1_sum: assert (sum_o == add_wide[WIDTH-1:0]) else $error("R1 sum mismatch");
      a_r2_carry: assert (carry_o == add_wide[WIDTH]) else $error("R2 carry mismatch");
      a_r5_add_ovf: assert (ovf_o == ovf_ref) else $error("R5 overflow mismatch");
      a_r6_no_overflow: assert ((op_a[WIDTH-1] == op_b[WIDTH-1]) || !ovf_o)
        else $error("R6 overflow on mixed signs");
    end else begin
      a_r3_diff: assert (sum_o == diff_ref) else $error("R3 difference mismatch");
      a_r4_borrow: assert (carry_o == no_borrow) else $error("R4 borrow mismatch");
      a_r7_sub_ovf: assert (ovf_o == ovf_ref) else $error("R7 overflow mismatch");
      a_r8_no_overflow: assert ((op_a[WIDTH-1] != op_b[WIDTH-1]) || !ovf_o)
        else $error("R8 overflow on equal signs");
    end
  end
endmodule

bind cla_addsub cla_addsub_chk #(.WIDTH(WIDTH)) u_chk (
  .op_a    (op_a),
  .op_b    (op_b),
  .sub_en  (sub_en),
  .carry_in(carry_in),
  .sum_o   (sum_o),
  .carry_o (carry_o),
  .ovf_o   (ovf_o)
);

// File: tb/cla_addsub_tb.sv
`timescale 1ns/1ps
module cla_addsub_tb;
  logic        clk;
  logic [15:0] op_a, op_b;
  logic        sub_en, carry_in;
  logic [15:0] sum_o;
  logic        carry_o, ovf_o;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  cla_addsub u_dut (
    .op_a(op_a), .op_b(op_b), .sub_en(sub_en), .carry_in(carry_in),
    .sum_o(sum_o), .carry_o(carry_o), .ovf_o(ovf_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // ripple-carry reference
  task automatic ref_model(input logic [15:0] a, input logic [15:0] b, input logic s,
                           input logic ci, output logic [15:0] r, output logic co,
                           output logic ov);
    logic c;
    logic bb;
    int sa, sb, res;
    c = s ? ~ci : ci;
    for (int i = 0; i < 16; i++) begin
      bb   = s ? ~b[i] : b[i];
      r[i] = a[i] ^ bb ^ c;
      c    = (a[i] & bb) | (a[i] & c) | (bb & c);
    end
    co = c;
    sa = a[15] ? int'(a) - 65536 : int'(a);
    sb = b[15] ? int'(b) - 65536 : int'(b);
    res = s ? sa - sb - int'(ci) : sa + sb + int'(ci);
    ov = (res > 32767) || (res < -32768);
  endtask

  task automatic apply(input logic [15:0] a, input logic [15:0] b, input logic s,
                       input logic ci, input string tag);
    logic [15:0] er;
    logic ec, eo;
    @(negedge clk);
    op_a = a; op_b = b; sub_en = s; carry_in = ci;
    #1;
    ref_model(a, b, s, ci, er, ec, eo);
    checks++;
    if (sum_o !== er) begin
      errors++;
      $display("FAIL %s sum a=%h b=%h sub=%b ci=%b actual=%h expected=%h", tag, a, b, s, ci, sum_o, er);
    end
    checks++;
    if (carry_o !== ec) begin
      errors++;
      $display("FAIL %s carry a=%h b=%h sub=%b ci=%b actual=%b expected=%b", tag, a, b, s, ci, carry_o, ec);
    end
    checks++;
    if (ovf_o !== eo) begin
      errors++;
      $display("FAIL %s ovf a=%h b=%h sub=%b ci=%b actual=%b expected=%b", tag, a, b, s, ci, ovf_o, eo);
    end
  endtask

  task automatic t_idle();
    apply(16'h0000, 16'h0000, 1'b0, 1'b0, "R1");
  endtask

  task automatic t_add_basic();   // R1 R2
    apply(16'h0007, 16'h0006, 1'b0, 1'b0, "R1");
    apply(16'h1234, 16'h4321, 1'b0, 1'b1, "R1");
    apply(16'hF000, 16'h1000, 1'b0, 1'b0, "R2");
    apply(16'h8001, 16'h8001, 1'b0, 1'b1, "R2");
  endtask

  task automatic t_add_ovf();     // R5 R6
    apply(16'h7FFF, 16'h0001, 1'b0, 1'b0, "R5");
    apply(16'h7FFF, 16'h0000, 1'b0, 1'b1, "R5");
    apply(16'h8000, 16'h8000, 1'b0, 1'b0, "R5");
    apply(16'h7FFF, 16'h8000, 1'b0, 1'b1, "R6");
    apply(16'hFFFF, 16'h0001, 1'b0, 1'b0, "R6");
  endtask

  task automatic t_sub();         // R3 R4
    apply(16'h0007, 16'h0006, 1'b1, 1'b0, "R3");
    apply(16'h0006, 16'h0007, 1'b1, 1'b0, "R4");
    apply(16'h0010, 16'h000F, 1'b1, 1'b1, "R4");
    apply(16'h0010, 16'h0010, 1'b1, 1'b1, "R3");
    apply(16'hFFFF, 16'hFFFF, 1'b1, 1'b0, "R3");
  endtask

  task automatic t_sub_ovf();     // R7 R8
    apply(16'h8000, 16'h0001, 1'b1, 1'b0, "R7");
    apply(16'h7FFF, 16'hFFFF, 1'b1, 1'b0, "R7");
    apply(16'h8000, 16'h0000, 1'b1, 1'b1, "R7");
    apply(16'h8000, 16'hFFFF, 1'b1, 1'b0, "R8");
    apply(16'h7FFF, 16'h0000, 1'b1, 1'b1, "R8");
  endtask

  task automatic t_chain();       // R9
    apply(16'hFFFF, 16'h0000, 1'b0, 1'b1, "R9");
    apply(16'h0FFF, 16'h0001, 1'b0, 1'b0, "R9");
    apply(16'h00FF, 16'h0001, 1'b0, 1'b0, "R9");
    apply(16'hFFFF, 16'hFFFF, 1'b0, 1'b1, "R9");
    apply(16'h0000, 16'h0001, 1'b1, 1'b0, "R9");
  endtask

  task automatic t_random();      // R1 R3 R5 R7
    for (int n = 0; n < 400; n++) begin
      logic [31:0] v;
      v = $urandom;
      apply(v[15:0], v[31:16], n[0], n[1], n[0] ? "R3" : "R1");
    end
  endtask

  initial begin
    #20000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    op_a = '0; op_b = '0; sub_en = 1'b0; carry_in = 1'b0;
    t_idle();
    t_add_basic();
    t_add_ovf();
    t_sub();
    t_sub_ovf();
    t_chain();
    t_random();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule